// File: doc/BRIEF.md
# Local-History Pattern Branch Direction Predictor

This block predicts whether a conditional branch is taken, for a simple in-order core. It keeps a shift register of recent branch outcomes. It combines that history with the low bits of the branch address by XOR, and the result selects one entry in a table of small per-entry state machines. Each entry is three bits wide. The entry records whether the branch has recently behaved steadily (always one way) or alternated, and how confident that view is. Bit 0 of the entry is the prediction.

The lookup side is purely combinational. The core presents the low address bits and, in the same cycle, receives the predicted direction and the table index it used. When the branch resolves, the core returns that index with the actual outcome on the update side. At the clock edge the block rewrites that one entry and shifts the outcome into the history. Because the table is written only at the edge, a lookup in the same cycle as an update always returns the value from before the update.

The eight entry states are: steady weak not-taken `ST_WNT` (000), steady weak taken `ST_WT` (001), steady strong not-taken `ST_SNT` (010), steady strong taken `ST_ST` (011), alternating weak predicting not-taken `ST_AWN` (100), alternating weak predicting taken `ST_AWT` (101), alternating strong predicting not-taken `ST_ASN` (110) and alternating strong predicting taken `ST_AST` (111). The named transitions are reinforce (a correct steady prediction), decay (a strong misprediction), switch-to-alternating, switch-to-steady, flip (a correct alternating prediction) and resync (a weak alternating misprediction whose phase is realigned).

Top module: `lhp_predictor`

## Requirements
- R1: A synchronous reset puts every entry in `ST_WNT`, so every lookup predicts not-taken, and clears the history to zero.
- R2: The lookup index `lk_idx` equals `lk_pc` XOR the history, with the history zero-extended to the index width. The index is valid in the same cycle.
- R3: Each update shifts the actual outcome into history bit 0; older bits move up one place and the oldest drops out. The history holds when there is no update.
- R4: `lk_taken` is bit 0 of the selected entry (bit 2 is alternating, bit 1 is strong, bit 0 is the predicted direction). A lookup in the same cycle as an update of the same entry returns the value from before the update.
- R5: Reinforce: a steady entry whose prediction matches the outcome becomes steady strong with the same prediction.
- R6: Decay (steady): a steady strong entry that mispredicts becomes steady weak, predicting the actual outcome.
- R7: A steady weak entry that mispredicts goes to alternating weak predicting the opposite of the outcome when the outcome differs from the previous outcome (history bit 0). Otherwise it goes to steady weak predicting the outcome.
- R8: Flip: an alternating entry that predicts correctly becomes alternating strong, predicting the opposite of the outcome.
- R9: Decay (alternating): an alternating strong entry that mispredicts becomes alternating weak, predicting the actual outcome.
- R10: An alternating weak entry that mispredicts goes to steady weak predicting the outcome when the outcome equals the previous outcome. Otherwise it resyncs to alternating weak, predicting the opposite of the outcome.
- R11: An update rewrites only the entry at `up_idx`; all other entries keep their state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| lk_pc | input | IW (6) | Low branch address bits for lookup |
| lk_taken | output | 1 | Predicted direction, 1 = taken |
| lk_idx | output | IW (6) | Table index used by this lookup |
| up_valid | input | 1 | Update strobe for a resolved branch |
| up_idx | input | IW (6) | Index returned from the earlier lookup |
| up_taken | input | 1 | Actual outcome of the resolved branch |

## Verification
The assertions assume that `up_idx` and `up_taken` are known whenever `up_valid` is high. They also assume that reset is held long enough for the first clock edge after it to see a cleared history. The bench drives every input from a known value on each falling edge and keeps reset high for several cycles. It brings out hidden entry state through prediction sequences. To do this it probes entries by picking `lk_pc` as the wanted index XOR its own model of the history, so every probe lands on the entry it intends.

// File: rtl/lhp_pkg.sv
package lhp_pkg;

    // bit 2: alternating pattern, bit 1: strong, bit 0: predicted direction
    typedef enum logic [2:0] {
        ST_WNT = 3'b000,
        ST_WT  = 3'b001,
        ST_SNT = 3'b010,
        ST_ST  = 3'b011,
        ST_AWN = 3'b100,
        ST_AWT = 3'b101,
        ST_ASN = 3'b110,
        ST_AST = 3'b111
    } lhp_state_e;

endpackage

// File: rtl/lhp_hash.sv
module lhp_hash #(
    parameter int IW = 6,
    parameter int HW = 4
) (
    input  logic [IW-1:0] pc,
    input  logic [HW-1:0] hist,
    output logic [IW-1:0] idx
);
    logic [IW-1:0] hist_fit;

    generate
        if (HW >= IW) begin : g_trunc
            assign hist_fit = hist[IW-1:0];
        end else begin : g_pad
            assign hist_fit = {{(IW-HW){1'b0}}, hist};
        end
    endgenerate

    assign idx = pc ^ hist_fit;

endmodule

// File: rtl/lhp_fsm.sv
module lhp_fsm
    import lhp_pkg::*;
(
    input  lhp_state_e cur,
    input  logic       outcome,
    input  logic       last,
    output lhp_state_e nxt
);
    always_comb begin
        nxt = cur;
        unique case (cur)
            // steady weak: reinforce, switch-to-alternating, or retarget
            ST_WNT: nxt = !outcome ? ST_SNT : ((outcome != last) ? ST_AWN : ST_WT);
            ST_WT:  nxt =  outcome ? ST_ST  : ((outcome != last) ? ST_AWT : ST_WNT);
            // steady strong: hold or decay
            ST_SNT: nxt =  outcome ? ST_WT  : ST_SNT;
            ST_ST:  nxt =  outcome ? ST_ST  : ST_WNT;
            // alternating weak: flip, switch-to-steady, or resync
            ST_AWN: nxt = !outcome ? ST_AST : ((outcome == last) ? ST_WT  : ST_AWN);
            ST_AWT: nxt =  outcome ? ST_ASN : ((outcome == last) ? ST_WNT : ST_AWT);
            // alternating strong: flip or decay
            ST_ASN: nxt = !outcome ? ST_AST : ST_AWT;
            ST_AST: nxt =  outcome ? ST_ASN : ST_AWN;
            default: nxt = ST_WNT;
        endcase
    end

endmodule

// File: rtl/lhp_table.sv
module lhp_table
    import lhp_pkg::*;
#(
    parameter int DEPTH = 64,
    localparam int IW = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [IW-1:0] rd_idx,
    output lhp_state_e    rd_state,
    input  logic [IW-1:0] wr_idx,
    output lhp_state_e    wr_cur,
    input  logic          wr_en,
    input  lhp_state_e    wr_state
);
    lhp_state_e mem [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= ST_WNT;
        end else if (wr_en) begin
            mem[wr_idx] <= wr_state;
        end
    end

    assign rd_state = mem[rd_idx];
    assign wr_cur   = mem[wr_idx];

endmodule

// File: rtl/lhp_predictor.sv
module lhp_predictor
    import lhp_pkg::*;
#(
    parameter int DEPTH = 64,
    parameter int HW    = 4,   // at least 2
    localparam int IW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [IW-1:0] lk_pc,
    output logic          lk_taken,
    output logic [IW-1:0] lk_idx,
    input  logic          up_valid,
    input  logic [IW-1:0] up_idx,
    input  logic          up_taken
);
    logic [HW-1:0] hist_q;
    lhp_state_e    rd_state, cur_state, nxt_state;

    always_ff @(posedge clk) begin
        if (rst)           hist_q <= '0;
        else if (up_valid) hist_q <= {hist_q[HW-2:0], up_taken};
    end

    lhp_hash #(.IW(IW), .HW(HW)) u_hash (
        .pc(lk_pc), .hist(hist_q), .idx(lk_idx)
    );

    lhp_table #(.DEPTH(DEPTH)) u_tab (
        .clk(clk), .rst(rst),
        .rd_idx(lk_idx), .rd_state(rd_state),
        .wr_idx(up_idx), .wr_cur(cur_state),
        .wr_en(up_valid), .wr_state(nxt_state)
    );

    lhp_fsm u_fsm (
        .cur(cur_state), .outcome(up_taken), .last(hist_q[0]), .nxt(nxt_state)
    );

    assign lk_taken = rd_state[0];

    AST_RST_CLEAR: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (hist_q == '0) && !lk_taken); // R1
    AST_HIST_SHIFT: assert property (@(posedge clk) disable iff (rst)
        up_valid |=> hist_q[0] == $past(up_taken)); // R3
    AST_HIST_HOLD: assert property (@(posedge clk) disable iff (rst)
        !up_valid |=> $stable(hist_q)); // R3
    AST_REINFORCE: assert property (@(posedge clk) disable iff (rst)
        (up_valid && !cur_state[2] && cur_state[0] == up_taken)
        |-> nxt_state == {2'b01, up_taken}); // R5
    AST_DECAY: assert property (@(posedge clk) disable iff (rst)
        (up_valid && cur_state[1] && cur_state[0] != up_taken)
        |-> !nxt_state[1] && nxt_state[2] == cur_state[2] && nxt_state[0] == up_taken); // R6
    AST_ALT_FLIP: assert property (@(posedge clk) disable iff (rst)
        (up_valid && cur_state[2] && cur_state[0] == up_taken)
        |-> nxt_state == {2'b11, !up_taken}); // R8

endmodule

// File: tb/sim_lhp_predictor.sv
`timescale 1ns/1ps
module sim_lhp_predictor;
    localparam int DEPTH = 64;
    localparam int HW    = 4;
    localparam int IW    = $clog2(DEPTH);

    logic clk = 1'b0;
    always #2 clk = ~clk;   // 250 MHz

    logic          rst = 1'b1;
    logic [IW-1:0] lk_pc = '0;
    logic          lk_taken;
    logic [IW-1:0] lk_idx;
    logic          up_valid = 1'b0;
    logic [IW-1:0] up_idx = '0;
    logic          up_taken = 1'b0;

    lhp_predictor #(.DEPTH(DEPTH), .HW(HW)) u0 (
        .clk(clk), .rst(rst), .lk_pc(lk_pc), .lk_taken(lk_taken), .lk_idx(lk_idx),
        .up_valid(up_valid), .up_idx(up_idx), .up_taken(up_taken)
    );

    typedef struct {
        string         tp;
        string         ti;
        logic          ep;
        logic [IW-1:0] ei;
    } item_t;
    item_t q[$];

    int nchk = 0;
    int nfail = 0;

    logic [2:0]    m_tab [DEPTH];
    logic [HW-1:0] m_hist = '0;

    // reference next state written from the requirement text
    function automatic logic [2:0] m_next(logic [2:0] s, logic o, logic l);
        if (!s[2]) begin
            if (o == s[0]) return {2'b01, o};       // R5
            if (s[1])      return {2'b00, o};       // R6
            if (o != l)    return {2'b10, ~o};      // R7
            return {2'b00, o};                      // R7
        end
        if (o == s[0]) return {2'b11, ~o};          // R8
        if (s[1])      return {2'b10, o};           // R9
        if (o == l)    return {2'b00, o};           // R10
        return {2'b10, ~o};                         // R10
    endfunction

    function automatic logic [IW-1:0] pc_for(logic [IW-1:0] idx);
        return idx ^ {{(IW-HW){1'b0}}, m_hist};
    endfunction

    task automatic cyc(input logic [IW-1:0] pc, input logic uv, input logic [IW-1:0] ui,
                       input logic ut, input string tp, input string ti);
        logic [IW-1:0] ix;
        @(negedge clk);
        lk_pc = pc; up_valid = uv; up_idx = ui; up_taken = ut;
        ix = pc ^ {{(IW-HW){1'b0}}, m_hist};
        q.push_back('{tp: tp, ti: ti, ep: m_tab[ix][0], ei: ix});
        if (uv) begin
            m_tab[ui] = m_next(m_tab[ui], ut, m_hist[0]);
            m_hist = {m_hist[HW-2:0], ut};
        end
    endtask

    task automatic probe(input logic [IW-1:0] idx, input string tp);
        cyc(pc_for(idx), 1'b0, '0, 1'b0, tp, "R2");
    endtask

    task automatic upd(input logic [IW-1:0] idx, input logic t, input string tp);
        cyc(pc_for(idx), 1'b1, idx, t, tp, "R2");
    endtask

    // monitor: compares queued expectations one time unit after the falling edge
    always @(negedge clk) begin
        #1;
        while (q.size() > 0) begin
            item_t it;
            it = q.pop_front();
            nchk++;
            if (lk_taken !== it.ep) begin
                nfail++;
                $display("FAIL %s prediction: actual %0b expected %0b", it.tp, lk_taken, it.ep);
            end
            nchk++;
            if (lk_idx !== it.ei) begin
                nfail++;
                $display("FAIL %s index: actual %0d expected %0d", it.ti, lk_idx, it.ei);
            end
        end
    end

    initial begin
        #(4 * 200000);
        nfail++;
        $display("FAIL watchdog: actual hung expected finished");
        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end

    localparam logic [IW-1:0] E = 6'd5;
    localparam logic [IW-1:0] F = 6'd9;
    localparam logic [IW-1:0] G = 6'd20;
    localparam logic [IW-1:0] H = 6'd30;

    initial begin
        for (int i = 0; i < DEPTH; i++) m_tab[i] = 3'b000;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        // R1: all entries predict not-taken, history cleared
        cyc(6'd0,  1'b0, '0, 1'b0, "R1", "R1");
        cyc(6'd37, 1'b0, '0, 1'b0, "R1", "R1");
        cyc(6'd63, 1'b0, '0, 1'b0, "R1", "R1");
        // R5 / R6 on entry E
        upd(E, 1'b0, "R4");
        probe(E, "R5");
        upd(E, 1'b1, "R4");
        probe(E, "R6");
        // R7: steady weak mispredict with outcome != previous
        upd(E, 1'b0, "R4");
        probe(E, "R7");
        // R8: flip twice
        upd(E, 1'b1, "R4");
        probe(E, "R8");
        upd(E, 1'b0, "R4");
        probe(E, "R8");
        // R9: strong alternating decay
        upd(E, 1'b0, "R4");
        probe(E, "R9");
        // R10: resync, then switch to steady
        upd(E, 1'b1, "R4");
        probe(E, "R10");
        upd(E, 1'b1, "R4");
        probe(E, "R10");
        // R11: untouched neighbours
        probe(6'd4, "R11");
        probe(6'd6, "R11");
        // R7 other branch: steady weak mispredict with outcome == previous
        upd(G, 1'b1, "R11");
        upd(F, 1'b1, "R7");
        probe(F, "R7");
        // R5 distinguishing test on H
        upd(H, 1'b0, "R5");
        upd(H, 1'b1, "R5");
        probe(H, "R5");
        // R3: history visible through index of pc 0
        upd(6'd2, 1'b1, "R3");
        upd(6'd2, 1'b0, "R3");
        upd(6'd2, 1'b1, "R3");
        cyc(6'd0, 1'b0, '0, 1'b0, "R3", "R3");
        cyc(6'd0, 1'b0, '0, 1'b0, "R3", "R3");
        upd(6'd3, 1'b1, "R3");
        cyc(6'd0, 1'b0, '0, 1'b0, "R3", "R3");
        // mixed traffic on a small set of entries
        for (int n = 0; n < 600; n++) begin
            cyc(6'($urandom), 1'($urandom), 6'($urandom % 8), 1'($urandom), "R11", "R2");
        end
        for (int i = 0; i < 8; i++) probe(6'(i), "R11");
        @(negedge clk);
        up_valid = 1'b0;
        repeat (3) @(negedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end

endmodule